// File: doc/BRIEF.md
# Two-Level Overcurrent Protection Timer

This block applies a current-limit policy to the drive of a PWM controller. It takes two digital trip flags from comparators that sit outside the block. A mild trip (`tripLow`) cuts only the present conduction period. Switching comes back at the next oscillator period start. A severe trip (`tripHigh`) shuts the converter down for a timed interval. During that interval the block stops switching, asks for the soft-start capacitor to be discharged, and runs a skip counter that always starts again from zero.

When the skip interval expires, the block does not restart on its own. It holds in a waiting state until `resumeOk` reports that the supply has reached its upper threshold again. Only then does it drop the discharge request and let a new soft-start begin. The real off-time is therefore never shorter than the programmed skip interval. A 2-bit code on `mode` shows which of the three states the block is in.

All three outputs are registered. Every response to an input is seen one clock cycle after the edge that samples that input.

Top module: `ocp_skip_timer`

## Requirements
- R1: While `rstN` is low, `pwmOut` is 0, `ssDischarge` is 0 and `mode` is 0 (normal).
- R2: In normal mode with no trip, `pwmOut` after an edge equals `pwmReq` sampled at that edge.
- R3: A `tripLow` sampled high forces `pwmOut` to 0 from the next cycle. The output then stays 0, even after `tripLow` falls, until an edge that samples `periodStart` high without `tripLow`. If `periodStart` and `tripLow` are high together, the trip wins.
- R4: A `tripHigh` sampled in normal mode gives `mode` = 1 (skip), `ssDischarge` = 1 and `pwmOut` = 0 in the next cycle.
- R5: When `tripLow` and `tripHigh` are high in the same cycle, the block enters skip mode (`mode` = 1).
- R6: Skip mode is seen on `mode` for exactly N consecutive cycles, where N is `skipLimit`. After that, `mode` becomes 2 (wait-for-restart).
- R7: A `skipLimit` of 0 acts as 1, so skip mode lasts exactly one cycle.
- R8: In skip mode, `resumeOk` is ignored. In wait mode without `resumeOk`, the block stays in wait with `ssDischarge` = 1 and `pwmOut` = 0.
- R9: A `resumeOk` sampled in wait mode returns the block to normal in the next cycle, with `ssDischarge` = 0 and `pwmOut` following `pwmReq`.
- R10: A `tripHigh` seen during skip mode does not restart the skip counter, so the interval length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStart | input | 1 | One-cycle strobe at the start of each oscillator period |
| pwmReq | input | 1 | Raw PWM drive request from the modulator |
| tripLow | input | 1 | Lower-threshold current trip flag |
| tripHigh | input | 1 | Higher-threshold current trip flag |
| resumeOk | input | 1 | Supply-good permission to begin a new soft-start |
| skipLimit | input | CNT_W (16) | Skip interval length in cycles (0 counts as 1) |
| pwmOut | output | 1 | Gated PWM drive |
| ssDischarge | output | 1 | Request to discharge the soft-start capacitor |
| mode | output | 2 | 0 = normal, 1 = skip, 2 = wait-for-restart |

## Verification
The bench builds the block with its default 16-bit counter. It drives `skipLimit` with the small values 5 and 0, so the exact number of skip-mode cycles, and the zero-means-one rule, can both be counted cycle by cycle within a short run. A retrigger of `tripHigh` and a stray `resumeOk` are placed mid-interval to show that neither one shortens or stretches the skip. A `periodStart` is placed in the same cycle as `tripLow` to show which of the two takes priority.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SKIP   = 2'd1,
    MODE_WAIT   = 2'd2
  } ocpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic allowPwm;
  } ocpStrobe_s;
endpackage

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tripHigh,
  input  logic       resumeOk,
  input  logic       cntDone,
  output ocpStrobe_s strobe,
  output ocpMode_e   mode,
  output logic       ssDischarge
);
  ocpMode_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      MODE_NORMAL: if (tripHigh) begin
        nextState     = MODE_SKIP;
        strobe.clrCnt = 1'b1;
      end
      MODE_SKIP: begin
        if (cntDone) nextState = MODE_WAIT;
        else         strobe.incCnt = 1'b1;
      end
      MODE_WAIT: if (resumeOk) nextState = MODE_NORMAL;
      default: nextState = MODE_NORMAL;
    endcase
    strobe.allowPwm = (nextState == MODE_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= MODE_NORMAL;
      ssDischarge <= 1'b0;
    end else begin
      state       <= nextState;
      ssDischarge <= (nextState != MODE_NORMAL);
    end
  end

  assign mode = state;

  // R4 / R5: a severe trip in normal mode always lands in skip
  assert_skip_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_NORMAL && tripHigh) |=> (state == MODE_SKIP));

  // R8: waiting holds until permission arrives
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_WAIT && !resumeOk) |=> (state == MODE_WAIT));

  // R6: skip never returns straight to normal
  assert_skip_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SKIP) |=> (state != MODE_NORMAL));
endmodule

// File: rtl/ocp_datapath.sv
module ocp_datapath
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ocpStrobe_s       strobe,
  input  logic [CNT_W-1:0] skipLimit,
  input  logic             periodStart,
  input  logic             pwmReq,
  input  logic             tripLow,
  input  logic             tripHigh,
  output logic             cntDone,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] skipCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             cutLatch, cutNext;

  // a zero limit behaves like one
  assign lastIdx = (skipLimit == '0) ? '0 : (skipLimit - ONE);
  assign cntDone = (skipCnt == lastIdx);

  // trip sets, period start clears, set wins
  assign cutNext = (cutLatch & ~periodStart) | tripLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipCnt  <= '0;
      cutLatch <= 1'b0;
      pwmOut   <= 1'b0;
    end else begin
      if (strobe.clrCnt)      skipCnt <= '0;
      else if (strobe.incCnt) skipCnt <= skipCnt + ONE;
      cutLatch <= cutNext;
      pwmOut   <= strobe.allowPwm & pwmReq & ~cutNext & ~tripHigh;
    end
  end

  // R3: a mild trip removes drive within one cycle
  assert_low_trip_cut_R3: assert property (@(posedge clk) disable iff (!rstN)
    tripLow |=> !pwmOut);

  // R6: the skip counter starts from zero on entry
  assert_count_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (skipCnt == '0));

  // R4: a severe trip removes drive within one cycle
  assert_high_trip_cut_R4: assert property (@(posedge clk) disable iff (!rstN)
    tripHigh |=> !pwmOut);
endmodule

// File: rtl/ocp_skip_timer.sv
module ocp_skip_timer
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic             pwmReq,
  input  logic             tripLow,
  input  logic             tripHigh,
  input  logic             resumeOk,
  input  logic [CNT_W-1:0] skipLimit,
  output logic             pwmOut,
  output logic             ssDischarge,
  output logic [1:0]       mode
);
  ocpStrobe_s strobe;
  ocpMode_e   modeState;
  logic       cntDone;

  ocp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tripHigh   (tripHigh),
    .resumeOk   (resumeOk),
    .cntDone    (cntDone),
    .strobe     (strobe),
    .mode       (modeState),
    .ssDischarge(ssDischarge)
  );

  ocp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .skipLimit  (skipLimit),
    .periodStart(periodStart),
    .pwmReq     (pwmReq),
    .tripLow    (tripLow),
    .tripHigh   (tripHigh),
    .cntDone    (cntDone),
    .pwmOut     (pwmOut)
  );

  assign mode = modeState;
endmodule

// File: tb/test_ocp_skip_timer.sv
module test_ocp_skip_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodStart = 0, pwmReq = 0, tripLow = 0, tripHigh = 0, resumeOk = 0;
  logic [15:0] skipLimit = 16'd5;
  logic pwmOut, ssDischarge;
  logic [1:0] mode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  bit        careQ[$];
  logic [3:0] expQ[$];
  string     tagQ[$];

  always #4 clk = ~clk;

  ocp_skip_timer i_ocp_skip_timer (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .pwmReq(pwmReq),
    .tripLow(tripLow), .tripHigh(tripHigh), .resumeOk(resumeOk),
    .skipLimit(skipLimit), .pwmOut(pwmOut), .ssDischarge(ssDischarge), .mode(mode)
  );

  // drive at negedge; the expected outputs appear after the following posedge
  task automatic drive(input logic ps, input logic req, input logic tl, input logic th,
                       input logic ro, input bit care, input logic ep, input logic es,
                       input logic [1:0] em, input string tag);
    @(negedge clk);
    periodStart = ps; pwmReq = req; tripLow = tl; tripHigh = th; resumeOk = ro;
    careQ.push_back(care);
    expQ.push_back({ep, es, em});
    tagQ.push_back(tag);
  endtask

  // monitor: pop and compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (careQ.size() > 0) begin
        bit c;
        logic [3:0] e;
        string t;
        c = careQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (c) begin
          nChecks++;
          if ({pwmOut, ssDischarge, mode} !== e) begin
            nFails++;
            $display("FAIL %s: got pwm=%b ss=%b mode=%0d, expected pwm=%b ss=%b mode=%0d",
                     t, pwmOut, ssDischarge, mode, e[3], e[2], e[1:0]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state, inputs active during reset
    pwmReq = 1; tripHigh = 1;
    repeat (3) @(posedge clk);
    #2;
    nChecks++;
    if ({pwmOut, ssDischarge, mode} !== 4'b0000) begin
      nFails++;
      $display("FAIL R1: got pwm=%b ss=%b mode=%0d, expected 0 0 0", pwmOut, ssDischarge, mode);
    end
    @(negedge clk);
    tripHigh = 0; pwmReq = 0; rstN = 1;

    // R2 normal pass-through
    drive(0, 1, 0, 0, 0, 1, 1, 0, 2'd0, "R2 req high");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 2'd0, "R2 req low");
    drive(0, 1, 0, 0, 0, 1, 1, 0, 2'd0, "R2 req high again");

    // R3 cycle-by-cycle cut held until period start
    drive(0, 1, 1, 0, 0, 1, 0, 0, 2'd0, "R3 trip cuts");
    drive(0, 1, 0, 0, 0, 1, 0, 0, 2'd0, "R3 held after trip falls");
    drive(0, 1, 0, 0, 0, 1, 0, 0, 2'd0, "R3 still held");
    drive(1, 1, 0, 0, 0, 1, 1, 0, 2'd0, "R3 resumes at period start");
    drive(1, 1, 1, 0, 0, 1, 0, 0, 2'd0, "R3 trip beats period start");
    drive(0, 1, 0, 0, 0, 1, 0, 0, 2'd0, "R3 held past coincident start");
    drive(1, 1, 0, 0, 0, 1, 1, 0, 2'd0, "R3 resumes next period");

    // R4/R6 skip with limit 5; R8 resume ignored in skip; R10 retrigger ignored
    drive(0, 1, 0, 1, 0, 1, 0, 1, 2'd1, "R4 enter skip");
    drive(0, 1, 0, 0, 1, 1, 0, 1, 2'd1, "R8 resume ignored in skip");
    drive(0, 1, 0, 1, 0, 1, 0, 1, 2'd1, "R10 retrigger ignored");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd1, "R6 skip cycle 4");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd1, "R6 skip cycle 5");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd2, "R6 wait after 5 cycles");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd2, "R8 wait holds");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd2, "R8 wait holds again");
    drive(0, 1, 0, 0, 1, 1, 1, 0, 2'd0, "R9 resume to normal");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 2'd0, "R9 pwm follows request");

    // R5 priority and R7 zero limit
    @(negedge clk);
    skipLimit = 16'd0;
    careQ.push_back(0); expQ.push_back(4'b0); tagQ.push_back("idle");
    drive(0, 1, 1, 1, 0, 1, 0, 1, 2'd1, "R5 both trips enter skip");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd2, "R7 zero limit one skip cycle");
    drive(0, 1, 0, 0, 0, 1, 0, 1, 2'd2, "R8 waiting");
    drive(1, 1, 0, 0, 1, 1, 1, 0, 2'd0, "R9 resume with period start");
    drive(0, 1, 0, 0, 0, 1, 1, 0, 2'd0, "R2 normal after restart");

    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    finish_run();
  end
endmodule